// File: doc/BRIEF.md
# DMA Channel Trigger Qualifier

This block sits beside one DMA channel's sequencer and decides when that channel is allowed to move data. It watches an external hardware trigger line, a peripheral request line, a one-cycle software trigger, descriptor completion and abort. From these it keeps a trigger flag and drives a transfer request toward the sequencer.

The hardware line first passes through a two-stage synchroniser. The line is then qualified by the channel's configuration. The polarity and the choice between edge and level sensing are selected independently.

Each trigger event arms a transfer credit. The credit covers either a single transfer or a burst of 2^n transfers. The sequencer reports each completed transfer with `xfer_done`. When the burst length is reached, the credit is spent. The trigger flag itself persists until one of three things happens:
- a descriptor that carries the clear bit completes;
- an abort is raised;
- in level mode, the qualified level goes away.

Top module: `dma_trig_qual`

## Requirements
- R1: After reset, `trig_flag` and `xfer_req` are both 0.
- R2: A `sw_trig` pulse sets `trig_flag` at the next clock edge and arms a transfer, so `xfer_req` rises in the same cycle as the flag.
- R3: When `cfg_hw_en` is 1 and `cfg_level` is 0, the line is edge sensed. A rising edge qualifies when `cfg_pol_high` is 1, and a falling edge qualifies when it is 0. A qualifying edge raises `trig_flag` on the third clock edge after the line changes. The opposite edge and a steady line never set it. With `cfg_hw_en` at 0, the line has no effect.
- R4: When `cfg_hw_en` is 1 and `cfg_level` is 1, the line is level sensed, and its active level is high when `cfg_pol_high` is 1. `trig_flag` follows the active level with the same three-edge latency. Transfers keep being granted while the level holds.
- R5: With `cfg_burst` at 0, one trigger event grants exactly one transfer. `xfer_req` falls after the clock edge that sees `xfer_done`, and `trig_flag` stays set.
- R6: With `cfg_burst` at 1, one trigger event grants 2^`cfg_burst_pow` transfers, with the exponent clamped to MAX_POW. `xfer_req` falls after the last of these transfers completes.
- R7: A `desc_done` pulse with `desc_clr_trig` at 1 clears `trig_flag` at the next edge. A `desc_done` pulse with `desc_clr_trig` at 0 leaves the flag set.
- R8: `abort` clears `trig_flag` and the transfer credit at the next edge, and it takes priority over a trigger event in the same cycle.
- R9: With `cfg_req_en` at 1, `xfer_req` is additionally gated combinationally by `periph_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| cfg_req_en | input | 1 | Gate requests with the peripheral request line |
| cfg_hw_en | input | 1 | Accept the hardware trigger line |
| cfg_pol_high | input | 1 | 1: rising edge or high level; 0: falling edge or low level |
| cfg_level | input | 1 | 1: level sensing; 0: edge sensing |
| cfg_burst | input | 1 | 1: one event grants a burst; 0: a single transfer |
| cfg_burst_pow | input | POW_W | Burst length exponent |
| hw_trig | input | 1 | Asynchronous hardware trigger line |
| periph_req | input | 1 | Peripheral request line |
| sw_trig | input | 1 | Software trigger pulse |
| desc_done | input | 1 | Current descriptor completed (pulse) |
| desc_clr_trig | input | 1 | Clear-trigger bit of the completing descriptor |
| abort | input | 1 | Abort the channel (pulse) |
| xfer_done | input | 1 | Sequencer finished one transfer (pulse) |
| trig_flag | output | 1 | Trigger flag |
| xfer_req | output | 1 | Transfer request toward the sequencer |

## Verification
The assertions assume a well-behaved environment:
- the sequencer pulses `xfer_done` only in a cycle where `xfer_req` is high;
- control pulses last one cycle;
- configuration bits change only while the flag is idle, or in ways the properties do not constrain.

The descriptor-clear property is written for cycles with the hardware path disabled, because a simultaneous hardware event would legally win. The stimulus drives every input on the falling clock edge and raises `xfer_done` only while a request is expected. It changes polarity or sensing mode only after the synchroniser has settled on a steady line, so that a mode switch never creates a spurious edge.

// File: rtl/dtq_pkg.sv
package dtq_pkg;

  typedef struct packed {
    logic hw_en;
    logic pol_high;
    logic level;
  } hw_mode_t;

  typedef enum logic [1:0] {
    FLAG_HOLD  = 2'd0,
    FLAG_SET   = 2'd1,
    FLAG_CLEAR = 2'd2
  } flag_op_e;

endpackage

// File: rtl/dtq_sync_edge.sv
module dtq_sync_edge
  import dtq_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     line_i,
  input  hw_mode_t mode_i,
  output logic     hw_evt_o,
  output logic     lvl_drop_o
);

  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q;
  logic              sync_s, lvl_act, rise, fall, edge_hit;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], line_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_s;
    end
  end

  always_comb begin
    sync_s     = sync_q[STAGES-1];
    lvl_act    = mode_i.pol_high ? sync_s : ~sync_s;
    rise       = sync_s & ~prev_q;
    fall       = ~sync_s & prev_q;
    edge_hit   = mode_i.pol_high ? rise : fall;
    hw_evt_o   = mode_i.hw_en & (mode_i.level ? lvl_act : edge_hit);
    lvl_drop_o = mode_i.hw_en & mode_i.level & ~lvl_act;
  end

endmodule

// File: rtl/dtq_flag.sv
module dtq_flag
  import dtq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic abort_i,
  input  logic clr_i,
  output logic flag_o
);

  flag_op_e op;
  logic     flag_q, flag_d;

  always_comb begin
    if (abort_i)    op = FLAG_CLEAR;
    else if (evt_i) op = FLAG_SET;
    else if (clr_i) op = FLAG_CLEAR;
    else            op = FLAG_HOLD;
  end

  always_comb begin
    case (op)
      FLAG_SET:   flag_d = 1'b1;
      FLAG_CLEAR: flag_d = 1'b0;
      default:    flag_d = flag_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/dtq_credit.sv
module dtq_credit #(
  parameter  int MAX_POW = 10,
  localparam int POW_W   = $clog2(MAX_POW + 1),
  localparam int CNT_W   = (MAX_POW < 1) ? 1 : MAX_POW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic             kill_i,
  input  logic             done_i,
  input  logic             burst_i,
  input  logic [POW_W-1:0] pow_i,
  output logic             credit_o
);

  logic             credit_q, credit_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, last_idx;
  logic [CNT_W:0]   span;
  logic [POW_W-1:0] pow_eff;
  logic             cnt_en;

  always_comb begin
    pow_eff  = (int'(pow_i) > MAX_POW) ? POW_W'(MAX_POW) : pow_i;
    span     = burst_i ? ((CNT_W + 1)'(1) << pow_eff) : (CNT_W + 1)'(1);
    last_idx = CNT_W'(span - (CNT_W + 1)'(1));
  end

  always_comb begin
    credit_d = credit_q;
    cnt_d    = cnt_q;
    cnt_en   = 1'b1;
    if (kill_i) begin
      credit_d = 1'b0;
      cnt_d    = '0;
    end else if (done_i && credit_q) begin
      if (cnt_q == last_idx) begin
        credit_d = evt_i;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end else if (evt_i && !credit_q) begin
      credit_d = 1'b1;
      cnt_d    = '0;
    end else begin
      cnt_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      credit_q <= 1'b0;
      cnt_q    <= '0;
    end else if (cnt_en) begin
      credit_q <= credit_d;
      cnt_q    <= cnt_d;
    end
  end

  assign credit_o = credit_q;

endmodule

// File: rtl/dma_trig_qual.sv
module dma_trig_qual
  import dtq_pkg::*;
#(
  parameter  int SYNC_STAGES = 2,
  parameter  int MAX_POW     = 10,
  localparam int POW_W       = $clog2(MAX_POW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_req_en,
  input  logic             cfg_hw_en,
  input  logic             cfg_pol_high,
  input  logic             cfg_level,
  input  logic             cfg_burst,
  input  logic [POW_W-1:0] cfg_burst_pow,
  input  logic             hw_trig,
  input  logic             periph_req,
  input  logic             sw_trig,
  input  logic             desc_done,
  input  logic             desc_clr_trig,
  input  logic             abort,
  input  logic             xfer_done,
  output logic             trig_flag,
  output logic             xfer_req
);

  hw_mode_t mode;
  logic     hw_evt, lvl_drop, evt, clr_any, kill, credit;

  always_comb begin
    mode.hw_en    = cfg_hw_en;
    mode.pol_high = cfg_pol_high;
    mode.level    = cfg_level;
  end

  dtq_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_i     (hw_trig),
    .mode_i     (mode),
    .hw_evt_o   (hw_evt),
    .lvl_drop_o (lvl_drop)
  );

  always_comb begin
    evt     = sw_trig | hw_evt;
    clr_any = (desc_done & desc_clr_trig) | lvl_drop;
    kill    = abort | (~evt & clr_any);
  end

  dtq_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt),
    .abort_i (abort),
    .clr_i   (clr_any),
    .flag_o  (trig_flag)
  );

  dtq_credit #(.MAX_POW(MAX_POW)) u_credit (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt),
    .kill_i   (kill),
    .done_i   (xfer_done),
    .burst_i  (cfg_burst),
    .pow_i    (cfg_burst_pow),
    .credit_o (credit)
  );

  assign xfer_req = trig_flag & credit & (~cfg_req_en | periph_req);

endmodule

// File: rtl/dma_trig_qual_chk.sv
module dma_trig_qual_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_req_en,
  input logic cfg_hw_en,
  input logic periph_req,
  input logic sw_trig,
  input logic desc_done,
  input logic desc_clr_trig,
  input logic abort,
  input logic trig_flag,
  input logic xfer_req
);

  assert_abort_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !trig_flag);

  assert_sw_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_trig && !abort) |=> trig_flag);

  assert_req_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> trig_flag);

  assert_periph_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_en && !periph_req) |-> !xfer_req);

  assert_desc_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_done && desc_clr_trig && !sw_trig && !cfg_hw_en) |=> !trig_flag);

  assert_hw_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_hw_en && !sw_trig && !trig_flag) |=> !trig_flag);

endmodule

bind dma_trig_qual dma_trig_qual_chk u_chk (.*);

// File: tb/dma_trig_qual_bench.sv
module dma_trig_qual_bench;

  typedef struct {
    logic  flag;
    logic  req;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_req_en, cfg_hw_en, cfg_pol_high, cfg_level, cfg_burst;
  logic [3:0] cfg_burst_pow;
  logic       hw_trig, periph_req, sw_trig, desc_done, desc_clr_trig, abort, xfer_done;
  logic       trig_flag, xfer_req;

  int   checks = 0;
  int   errors = 0;
  bit   finished = 0;
  exp_t sb[$];

  always #4 clk = ~clk;

  dma_trig_qual u_dma_trig_qual (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_req_en    (cfg_req_en),
    .cfg_hw_en     (cfg_hw_en),
    .cfg_pol_high  (cfg_pol_high),
    .cfg_level     (cfg_level),
    .cfg_burst     (cfg_burst),
    .cfg_burst_pow (cfg_burst_pow),
    .hw_trig       (hw_trig),
    .periph_req    (periph_req),
    .sw_trig       (sw_trig),
    .desc_done     (desc_done),
    .desc_clr_trig (desc_clr_trig),
    .abort         (abort),
    .xfer_done     (xfer_done),
    .trig_flag     (trig_flag),
    .xfer_req      (xfer_req)
  );

  // Monitor: compares outputs 2 ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (trig_flag !== e.flag || xfer_req !== e.req) begin
          errors++;
          $display("FAIL %s: flag/req actual %b/%b expected %b/%b",
                   e.tag, trig_flag, xfer_req, e.flag, e.req);
        end
      end
    end
  end

  // Driver helper: inputs are already set at a falling edge.
  task automatic step(input string tag, input logic ef, input logic er);
    exp_t e;
    e.flag = ef;
    e.req  = er;
    e.tag  = tag;
    sb.push_back(e);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    {cfg_req_en, cfg_hw_en, cfg_pol_high, cfg_level, cfg_burst} = '0;
    cfg_burst_pow = 4'd0;
    {hw_trig, periph_req, sw_trig, desc_done, desc_clr_trig, abort, xfer_done} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step("R1", 0, 0);

    // Software trigger and single transfer
    sw_trig = 1; step("R2", 1, 1); sw_trig = 0;
    xfer_done = 1; step("R5", 1, 0); xfer_done = 0;
    step("R5", 1, 0);

    // Descriptor completion
    desc_done = 1; desc_clr_trig = 0; step("R7", 1, 0);
    desc_clr_trig = 1; step("R7", 0, 0);
    desc_done = 0; desc_clr_trig = 0;

    // Burst of four
    cfg_burst = 1; cfg_burst_pow = 4'd2;
    sw_trig = 1; step("R6", 1, 1); sw_trig = 0;
    xfer_done = 1;
    for (int i = 0; i < 3; i++) step("R6", 1, 1);
    step("R6", 1, 0);
    xfer_done = 0;

    // Abort, and abort beating a trigger
    abort = 1; step("R8", 0, 0); abort = 0;
    cfg_burst = 0;
    sw_trig = 1; abort = 1; step("R8", 0, 0);
    sw_trig = 0; abort = 0;
    step("R8", 0, 0);

    // Rising edge
    cfg_hw_en = 1; cfg_pol_high = 1;
    step("R3", 0, 0);
    hw_trig = 1;
    step("R3", 0, 0); step("R3", 0, 0); step("R3", 1, 1); step("R3", 1, 1);
    desc_done = 1; desc_clr_trig = 1; step("R7", 0, 0);
    desc_done = 0; desc_clr_trig = 0;
    step("R3", 0, 0); step("R3", 0, 0);
    hw_trig = 0;
    for (int i = 0; i < 3; i++) step("R3", 0, 0);

    // Falling edge
    cfg_pol_high = 0;
    hw_trig = 1;
    for (int i = 0; i < 3; i++) step("R3", 0, 0);
    hw_trig = 0;
    step("R3", 0, 0); step("R3", 0, 0); step("R3", 1, 1);
    abort = 1; step("R8", 0, 0); abort = 0;

    // Hardware path disabled
    cfg_hw_en = 0; cfg_pol_high = 1;
    hw_trig = 1;
    for (int i = 0; i < 4; i++) step("R3", 0, 0);
    hw_trig = 0;
    for (int i = 0; i < 3; i++) step("R3", 0, 0);

    // Level high
    cfg_hw_en = 1; cfg_level = 1; cfg_pol_high = 1;
    step("R4", 0, 0);
    hw_trig = 1;
    step("R4", 0, 0); step("R4", 0, 0); step("R4", 1, 1);
    xfer_done = 1;
    for (int i = 0; i < 3; i++) step("R4", 1, 1);
    xfer_done = 0;

    // Peripheral gating
    cfg_req_en = 1; periph_req = 0; step("R9", 1, 0);
    periph_req = 1; step("R9", 1, 1);
    cfg_req_en = 0; periph_req = 0;

    hw_trig = 0;
    step("R4", 1, 1); step("R4", 1, 1); step("R4", 0, 0); step("R4", 0, 0);

    // Level low
    cfg_pol_high = 0; step("R4", 1, 1);
    hw_trig = 1;
    step("R4", 1, 1); step("R4", 1, 1); step("R4", 0, 0);

    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule